// File: doc/BRIEF.md
# Correlator Accumulation Status Word

This block builds a 15-bit read-only status word for a twelve-channel correlator. The word tells the host four things: which channels have lost accumulated results, whether a periodic tick has occurred, whether fresh measurement data is due, and the current level of one external input pin. The correlator arithmetic and the bus decoding sit outside the block. The block only sees strobes: per-channel dump, data-read, accumulator-clear and enable lines; a tick pulse with its programmed period; an accumulation-interrupt line; host read and write strobes for the status address; and two resets.

Each channel tracks whether its latest dump has been read. A second dump that arrives before that read marks an internal loss flag. The host does not see that flag directly. Its visible copy is updated only on the rising edge of the accumulation interrupt or on a host write to the status address. Disabling a channel clears its visible bit at once. The tick and measurement flags are cleared when the host reads the word. The measurement flag is also raised a fixed number of cycles before each expected tick. The two reset sources clear different parts of the word: the hardware reset clears all registered state, and the software master reset clears only the per-channel state.

Top module: `corr_accum_status`

## Requirements
- R1: While the hardware reset is asserted and immediately after it is released, bits 13 down to 0 of `status_o` read 0.
- R2: Bit 14 follows `pin_in` through a two-stage synchronizer, so it shows a new pin level two clock edges after the change. The software master reset does not change it.
- R3: Bit 13 becomes 1 on the edge after a `tick` pulse and becomes 0 on the edge after a `stat_rd` pulse. When `tick` and `stat_rd` occur in the same cycle, the bit stays at 1. The software master reset does not clear it.
- R4: When `irq_en` is 1, a `tick` sets bit 12 on the next edge. When `irq_en` is 0, a `tick` leaves bit 12 at 0.
- R5: Suppose `irq_en` is 1 and the `tick_period` value latched at a tick is greater than LEAD. Then bit 12 becomes 1 exactly `tick_period - LEAD` edges after that tick. When `tick_period` is LEAD or less, no early set occurs.
- R6: A `stat_rd` clears bit 12 on the next edge. When a set event occurs in the same cycle as `stat_rd`, the bit stays at 1. The software master reset does not clear it.
- R7: For channel i, bit i is the visible loss flag. The internal loss flag for the channel is raised when a dump arrives while the previous dump is still unread. A dump that arrives in the same cycle as that channel's read does not raise it.
- R8: An internal loss flag stays set until that channel's `ch_clr` strobe is given. Once cleared, it is no longer copied into the visible bit.
- R9: A visible loss bit takes the internal flag's value only on a rising edge of `accum_irq` or on a `stat_wr` pulse. Holding `accum_irq` high does not update it again.
- R10: When `ch_en[i]` is 0, bit i reads 0 in the same cycle. While the channel is disabled, its unread and loss state is discarded.
- R11: `sw_rst` clears every channel's unread state, internal loss flag and visible loss flag. Bits 14 to 12 are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software master reset pulse, synchronous |
| ch_dump | input | NCH | Per-channel dump strobe: new accumulated data is ready |
| ch_read | input | NCH | Per-channel strobe: the accumulated data was read |
| ch_clr | input | NCH | Per-channel accumulator-clear write strobe |
| ch_en | input | NCH | Per-channel enable |
| tick | input | 1 | Tick pulse |
| tick_period | input | PW | Tick period in clock cycles |
| irq_en | input | 1 | Interrupt enable for the measurement flag |
| accum_irq | input | 1 | Accumulation interrupt; its rising edge samples the loss flags |
| stat_wr | input | 1 | Host write strobe to the status address |
| stat_rd | input | 1 | Host read strobe of the status word |
| pin_in | input | 1 | Raw external input pin |
| status_o | output | NCH+3 | Status word: bit 14 is the pin, 13 the tick flag, 12 the measurement flag, 11..0 the channel loss flags |

## Verification
The hardest state to reach is one where a channel's internal loss flag and its visible bit disagree. The stimulus gets there with two dumps and no read in between, then holds back any sampling event. It then checks that the visible bit is still 0 while `accum_irq` stays high, and updates only after `accum_irq` drops and rises again. The early measurement set needs the counter to run a full `tick_period - LEAD` cycles with no further tick. The stimulus therefore reads the flag clear right after the tick and counts the cycles to the edge just before the set and the edge on which it occurs.

// File: rtl/corr_stat_pkg.sv
package corr_stat_pkg;

    typedef struct packed {
        logic unread;
        logic missed;
        logic vis;
    } chan_state_t;

    typedef struct packed {
        logic tick_flag;
        logic meas_flag;
        logic armed;
    } flag_state_t;

endpackage

// File: rtl/corr_pin_sync.sv
module corr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_in,
    output logic pin_o
);
    logic [STAGES-1:0] sync_d;
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = pin_in;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], pin_in};
        end
    endgenerate

    // No reset: the pin level is never cleared by either reset.
    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign pin_o = sync_q[STAGES-1];
endmodule

// File: rtl/corr_chan_track.sv
module corr_chan_track
    import corr_stat_pkg::*;
(
    input  logic clk,
    input  logic hw_rst_n,
    input  logic sw_rst,
    input  logic dump,
    input  logic rd,
    input  logic clr,
    input  logic en,
    input  logic sample,
    output logic vis_o
);
    chan_state_t st_d;
    chan_state_t st_q;
    logic        miss_ev;

    always_comb begin
        st_d    = st_q;
        miss_ev = dump && st_q.unread && !rd;
        if (!en || sw_rst) begin
            st_d = '0;
        end else begin
            st_d.unread = dump || (st_q.unread && !rd);
            st_d.missed = miss_ev || (st_q.missed && !clr);
            if (sample) begin
                st_d.vis = st_q.missed;
            end
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Disabling clears the visible bit without waiting for a clock edge.
    assign vis_o = st_q.vis && en;
endmodule

// File: rtl/corr_event_flags.sv
module corr_event_flags
    import corr_stat_pkg::*;
#(
    parameter int PW   = 24,
    parameter int LEAD = 50
) (
    input  logic          clk,
    input  logic          hw_rst_n,
    input  logic          tick,
    input  logic [PW-1:0] tick_period,
    input  logic          irq_en,
    input  logic          stat_rd,
    output logic          tick_flag_o,
    output logic          meas_flag_o
);
    localparam logic [PW-1:0] LEAD_W = PW'(LEAD);
    localparam logic [PW-1:0] ONE_W  = PW'(1);

    flag_state_t   fl_d;
    flag_state_t   fl_q;
    logic [PW-1:0] cnt_d;
    logic [PW-1:0] cnt_q;
    logic          early;
    logic          meas_set;

    always_comb begin
        fl_d     = fl_q;
        cnt_d    = cnt_q;
        early    = fl_q.armed && (cnt_q == ONE_W);
        meas_set = irq_en && (tick || early);

        if (tick) begin
            if (tick_period > LEAD_W) begin
                fl_d.armed = 1'b1;
                cnt_d      = tick_period - LEAD_W;
            end else begin
                fl_d.armed = 1'b0;
                cnt_d      = '0;
            end
        end else if (fl_q.armed) begin
            cnt_d = cnt_q - ONE_W;
            if (early) begin
                fl_d.armed = 1'b0;
            end
        end

        // Set wins over clear-on-read.
        fl_d.tick_flag = tick || (fl_q.tick_flag && !stat_rd);
        fl_d.meas_flag = meas_set || (fl_q.meas_flag && !stat_rd);
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            fl_q  <= '0;
            cnt_q <= '0;
        end else begin
            fl_q  <= fl_d;
            cnt_q <= cnt_d;
        end
    end

    assign tick_flag_o = fl_q.tick_flag;
    assign meas_flag_o = fl_q.meas_flag;
endmodule

// File: rtl/corr_accum_status.sv
module corr_accum_status #(
    parameter int NCH         = 12,
    parameter int PW          = 24,
    parameter int LEAD        = 50,
    parameter int SYNC_STAGES = 2,
    localparam int SW         = NCH + 3
) (
    input  logic           clk,
    input  logic           hw_rst_n,
    input  logic           sw_rst,
    input  logic [NCH-1:0] ch_dump,
    input  logic [NCH-1:0] ch_read,
    input  logic [NCH-1:0] ch_clr,
    input  logic [NCH-1:0] ch_en,
    input  logic           tick,
    input  logic [PW-1:0]  tick_period,
    input  logic           irq_en,
    input  logic           accum_irq,
    input  logic           stat_wr,
    input  logic           stat_rd,
    input  logic           pin_in,
    output logic [SW-1:0]  status_o
);
    localparam int MEAS_BIT = NCH;
    localparam int TICK_BIT = NCH + 1;
    localparam int PIN_BIT  = NCH + 2;

    logic           acc_prev_d;
    logic           acc_prev_q;
    logic           sample;
    logic [NCH-1:0] vis;
    logic           tick_flag;
    logic           meas_flag;
    logic           pin_s;

    always_comb begin
        acc_prev_d = accum_irq;
        sample     = stat_wr || (accum_irq && !acc_prev_q);
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            acc_prev_q <= 1'b0;
        end else begin
            acc_prev_q <= acc_prev_d;
        end
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            corr_chan_track u_chan (
                .clk      (clk),
                .hw_rst_n (hw_rst_n),
                .sw_rst   (sw_rst),
                .dump     (ch_dump[i]),
                .rd       (ch_read[i]),
                .clr      (ch_clr[i]),
                .en       (ch_en[i]),
                .sample   (sample),
                .vis_o    (vis[i])
            );
        end
    endgenerate

    corr_event_flags #(
        .PW   (PW),
        .LEAD (LEAD)
    ) u_flags (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .tick        (tick),
        .tick_period (tick_period),
        .irq_en      (irq_en),
        .stat_rd     (stat_rd),
        .tick_flag_o (tick_flag),
        .meas_flag_o (meas_flag)
    );

    corr_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .pin_in (pin_in),
        .pin_o  (pin_s)
    );

    always_comb begin
        status_o            = '0;
        status_o[NCH-1:0]   = vis;
        status_o[MEAS_BIT]  = meas_flag;
        status_o[TICK_BIT]  = tick_flag;
        status_o[PIN_BIT]   = pin_s;
    end
endmodule

// File: rtl/corr_accum_status_chk.sv
module corr_accum_status_chk #(
    parameter int NCH = 12
) (
    input logic           clk,
    input logic           hw_rst_n,
    input logic           sw_rst,
    input logic           tick,
    input logic           irq_en,
    input logic           stat_rd,
    input logic           stat_wr,
    input logic           accum_irq,
    input logic [NCH-1:0] ch_en,
    input logic [NCH+2:0] status_o
);
    logic acc_seen_q;

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            acc_seen_q <= 1'b0;
        end else begin
            acc_seen_q <= accum_irq;
        end
    end

    // R3
    tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        tick |=> status_o[NCH+1]);

    // R3
    read_clears_tick_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (stat_rd && !tick) |=> !status_o[NCH+1]);

    // R4
    meas_on_tick_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (tick && irq_en) |=> status_o[NCH]);

    // R6
    sw_rst_keeps_meas_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_rst && status_o[NCH] && !stat_rd) |=> status_o[NCH]);

    // R9
    no_refresh_without_event_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!stat_wr && !(accum_irq && !acc_seen_q))
        |=> ((status_o[NCH-1:0] & ~$past(status_o[NCH-1:0])) == '0));

    // R10
    disabled_reads_zero_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (status_o[NCH-1:0] & ~ch_en) == '0);

    // R11
    sw_rst_clears_chan_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst |=> (status_o[NCH-1:0] == '0));
endmodule

bind corr_accum_status corr_accum_status_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .hw_rst_n  (hw_rst_n),
    .sw_rst    (sw_rst),
    .tick      (tick),
    .irq_en    (irq_en),
    .stat_rd   (stat_rd),
    .stat_wr   (stat_wr),
    .accum_irq (accum_irq),
    .ch_en     (ch_en),
    .status_o  (status_o)
);

// File: tb/corr_accum_status_bench.sv
module corr_accum_status_bench;
    localparam int NCH  = 12;
    localparam int PW   = 24;
    localparam int LEAD = 50;

    logic           clk = 1'b0;
    logic           hw_rst_n;
    logic           sw_rst;
    logic [NCH-1:0] ch_dump;
    logic [NCH-1:0] ch_read;
    logic [NCH-1:0] ch_clr;
    logic [NCH-1:0] ch_en;
    logic           tick;
    logic [PW-1:0]  tick_period;
    logic           irq_en;
    logic           accum_irq;
    logic           stat_wr;
    logic           stat_rd;
    logic           pin_in;
    logic [NCH+2:0] status_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    corr_accum_status #(.NCH(NCH), .PW(PW), .LEAD(LEAD)) u_corr_accum_status (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .sw_rst      (sw_rst),
        .ch_dump     (ch_dump),
        .ch_read     (ch_read),
        .ch_clr      (ch_clr),
        .ch_en       (ch_en),
        .tick        (tick),
        .tick_period (tick_period),
        .irq_en      (irq_en),
        .accum_irq   (accum_irq),
        .stat_wr     (stat_wr),
        .stat_rd     (stat_rd),
        .pin_in      (pin_in),
        .status_o    (status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        sw_rst = 0; ch_dump = '0; ch_read = '0; ch_clr = '0;
        tick = 0; stat_wr = 0; stat_rd = 0;
    endtask

    task automatic pulse_wr();
        stat_wr = 1; cyc(); stat_wr = 0;
    endtask

    task automatic t_reset();
        hw_rst_n = 0; clear_strobes();
        ch_en = '1; irq_en = 1; accum_irq = 0; pin_in = 0; tick_period = 24'd100;
        repeat (3) cyc();
        check("R1 during reset", 32'(status_o[13:0]), 32'h0);
        hw_rst_n = 1; cyc();
        check("R1 after reset", 32'(status_o[13:0]), 32'h0);
    endtask

    task automatic t_pin();
        pin_in = 1; cyc();
        check("R2 pin after one edge", 32'(status_o[14]), 32'h0);
        cyc();
        check("R2 pin after two edges", 32'(status_o[14]), 32'h1);
        sw_rst = 1; cyc(); sw_rst = 0;
        check("R2 pin kept over sw_rst", 32'(status_o[14]), 32'h1);
        pin_in = 0; cyc(); cyc();
        check("R2 pin low", 32'(status_o[14]), 32'h0);
    endtask

    task automatic t_tick();
        irq_en = 0; tick_period = 24'd10;
        tick = 1; cyc(); tick = 0;
        check("R3 tick sets bit13", 32'(status_o[13]), 32'h1);
        check("R4 no meas without irq_en", 32'(status_o[12]), 32'h0);
        stat_rd = 1; tick = 1; cyc(); stat_rd = 0; tick = 0;
        check("R3 set wins over read", 32'(status_o[13]), 32'h1);
        sw_rst = 1; cyc(); sw_rst = 0;
        check("R3 sw_rst keeps tick flag", 32'(status_o[13]), 32'h1);
        stat_rd = 1; cyc(); stat_rd = 0;
        check("R3 read clears bit13", 32'(status_o[13]), 32'h0);
        irq_en = 1;
    endtask

    task automatic t_meas();
        tick_period = 24'd100;
        tick = 1; cyc(); tick = 0;
        check("R4 tick sets bit12", 32'(status_o[12]), 32'h1);
        sw_rst = 1; cyc(); sw_rst = 0;
        check("R6 sw_rst keeps bit12", 32'(status_o[12]), 32'h1);
        stat_rd = 1; cyc(); stat_rd = 0;
        check("R6 read clears bit12", 32'(status_o[12]), 32'h0);
        repeat (47) cyc();
        check("R5 no early set one edge before", 32'(status_o[12]), 32'h0);
        stat_rd = 1; cyc(); stat_rd = 0;
        check("R5 R6 early set wins over read", 32'(status_o[12]), 32'h1);
        stat_rd = 1; cyc(); stat_rd = 0;
        repeat (60) cyc();
        check("R5 single early set per tick", 32'(status_o[12]), 32'h0);
        tick_period = 24'd40;
        tick = 1; cyc(); tick = 0;
        stat_rd = 1; cyc(); stat_rd = 0;
        repeat (60) cyc();
        check("R5 no early set for short period", 32'(status_o[12]), 32'h0);
        stat_rd = 1; cyc(); stat_rd = 0;
    endtask

    task automatic t_missed();
        ch_dump[0] = 1; cyc(); ch_dump[0] = 0;
        ch_dump[0] = 1; cyc(); ch_dump[0] = 0;
        check("R9 loss hidden before sample", 32'(status_o[0]), 32'h0);
        pulse_wr();
        check("R7 loss visible after write", 32'(status_o[0]), 32'h1);
        ch_clr[0] = 1; cyc(); ch_clr[0] = 0;
        check("R9 bit held after clear until sample", 32'(status_o[0]), 32'h1);
        accum_irq = 1; cyc();
        check("R8 cleared flag sampled on irq edge", 32'(status_o[0]), 32'h0);
        accum_irq = 0; cyc();
        ch_read[0] = 1; cyc(); ch_read[0] = 0;
        ch_dump[3] = 1; cyc();
        ch_read[3] = 1; cyc(); ch_dump[3] = 0; ch_read[3] = 0;
        pulse_wr();
        check("R7 dump with same-cycle read is no loss", 32'(status_o[3]), 32'h0);
        ch_dump[4] = 1; cyc(); cyc(); ch_dump[4] = 0;
        repeat (5) cyc();
        pulse_wr();
        check("R8 loss latched without clear", 32'(status_o[4]), 32'h1);
    endtask

    task automatic t_refresh_level();
        accum_irq = 1; cyc();
        ch_dump[9] = 1; cyc(); cyc(); ch_dump[9] = 0;
        repeat (3) cyc();
        check("R9 held irq level gives no refresh", 32'(status_o[9]), 32'h0);
        accum_irq = 0; cyc();
        check("R9 falling irq gives no refresh", 32'(status_o[9]), 32'h0);
        accum_irq = 1; cyc();
        check("R9 rising irq refreshes", 32'(status_o[9]), 32'h1);
        accum_irq = 0; cyc();
    endtask

    task automatic t_disable();
        ch_dump[5] = 1; cyc(); cyc(); ch_dump[5] = 0;
        pulse_wr();
        check("R7 ch5 loss visible", 32'(status_o[5]), 32'h1);
        ch_en[5] = 0; #1;
        check("R10 disable clears bit at once", 32'(status_o[5]), 32'h0);
        cyc(); ch_en[5] = 1; cyc();
        pulse_wr();
        check("R10 state discarded while disabled", 32'(status_o[5]), 32'h0);
    endtask

    task automatic t_swrst();
        ch_dump[7] = 1; cyc(); cyc(); ch_dump[7] = 0;
        pulse_wr();
        tick = 1; cyc(); tick = 0;
        check("R7 ch7 loss visible", 32'(status_o[7]), 32'h1);
        sw_rst = 1; cyc(); sw_rst = 0;
        check("R11 sw_rst clears visible bit", 32'(status_o[7]), 32'h0);
        check("R11 sw_rst keeps tick and meas", 32'(status_o[13:12]), 32'h3);
        pulse_wr();
        check("R11 sw_rst cleared internal loss", 32'(status_o[7]), 32'h0);
        ch_dump[7] = 1; cyc(); ch_dump[7] = 0;
        pulse_wr();
        check("R11 sw_rst cleared unread state", 32'(status_o[7]), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pin();
        t_tick();
        t_meas();
        t_missed();
        t_refresh_level();
        t_disable();
        t_swrst();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule